// File: doc/BRIEF.md
# Streaming Binary Morphology Engine (9x9 Dilate / Erode)

This block cleans a one-bit object mask as it streams past in raster order. Each input bit is 1 for object and 0 for background. For every pixel position it looks at the 9x9 square centred on that pixel and produces one output bit. In dilation mode the output is 1 if any pixel in the square is set, which fills holes and gaps. In erosion mode the output is 1 only if every pixel in the square is set, which removes isolated specks. Both modes share one datapath. Eight line buffers, each one image row long, feed a 9x9 shift window. The 81-input reduction is split into per-row reductions and a final column reduction on separate pipeline registers, so one result leaves per clock.

Input and output use a valid/ready handshake with frame markers. A frame begins with the pixel that carries the start marker, and the mode is captured at that pixel. After the last input pixel the engine drains the remaining four rows and four pixels on its own, so every frame emits exactly width x height output bits in raster order. Positions outside the frame count as 0 when dilating and as 1 when eroding, so the border does not bias the result. The default geometry is 320x240.

Top module: `morph_stream`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: In dilation mode (mode_erode = 0), each output bit is the OR of the input bits whose column and row both lie within 4 of the output position and inside the frame.
- R3: In erosion mode (mode_erode = 1), each output bit is the AND of the input bits whose column and row both lie within 4 of the output position, with positions outside the frame counted as 1.
- R4: At the frame border, positions outside the frame have no effect. An all-ones frame eroded stays all ones. A single set corner pixel, dilated, gives a set 5x5 patch clipped to that corner.
- R5: mode_erode is sampled only with the pixel that carries in_sof. Changing it later in the frame does not change that frame's output.
- R6: While no frame is in progress, a pixel accepted with in_sof = 0 is discarded and does not appear in any output frame.
- R7: Each frame yields exactly IMG_W*IMG_H outputs in raster order. out_sof is 1 only on the first output, out_eol is 1 on the last output of each row, and out_eof is 1 only on the final output.
- R8: After the last input pixel of a frame, in_ready is 0 while the engine drains 4*IMG_W+4 positions, and the frame completes with no further input.
- R9: While out_valid is 1 and out_ready is 0, out_valid, out_bit and all output markers hold steady, and no result is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_erode | input | 1 | 1 selects erosion, 0 selects dilation; sampled at frame start |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Engine accepts the input pixel |
| in_bit | input | 1 | Input mask pixel |
| in_sof | input | 1 | Marks the first pixel of a frame |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_bit | output | 1 | Filtered mask pixel |
| out_sof | output | 1 | First output pixel of a frame |
| out_eol | output | 1 | Last output pixel of a row |
| out_eof | output | 1 | Last output pixel of a frame |

## Verification
A line buffer pointer that is off by one shifts rows against each other. This shows within the first output rows as a diagonal smear of the dilated corner patch or of random specks. A wrong coordinate mask or padding value corrupts only the border ring, four pixels deep, so each frame is compared bit by bit at every position, edges included. Counting or drain faults show at the end of a frame as a missing, extra or misplaced end-of-frame marker, or as a stuck in_ready on the next frame. A mode latch error shows in the same frame as the mode change.

// File: rtl/morph_pkg.sv
package morph_pkg;
  localparam int KSIZE = 9;
  localparam int HALF  = 4;
  localparam int NLINE = KSIZE - 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } seq_state_t;
endpackage

// File: rtl/morph_linebuf.sv
module morph_linebuf #(
  parameter int LEN = 320
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic din,
  output logic dout
);
  localparam int AW = (LEN > 1) ? $clog2(LEN) : 1;

  logic [LEN-1:0] mem_q;
  logic [AW-1:0]  ptr_q;
  logic [AW-1:0]  ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (shift_en) begin
      if (ptr_q == AW'(LEN - 1)) ptr_d = '0;
      else                       ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // storage: the old bit at the pointer leaves as the new one enters
  always_ff @(posedge clk) begin
    if (shift_en) mem_q[ptr_q] <= din;
  end

  assign dout = mem_q[ptr_q];

  // R7
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= AW'(LEN - 1));
endmodule

// File: rtl/morph_seq.sv
module morph_seq
  import morph_pkg::*;
#(
  parameter int IMG_W = 320,
  parameter int IMG_H = 240,
  parameter int XW    = $clog2(IMG_W),
  parameter int YW    = $clog2(IMG_H)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_bit,
  input  logic          mode_in,
  output logic          in_ready,
  output logic          step,
  output logic          push_bit,
  output logic          emit,
  output logic [XW-1:0] cx,
  output logic [YW-1:0] cy,
  output logic          mode_q
);
  localparam int NPIX  = IMG_W * IMG_H;
  localparam int OFF   = HALF * IMG_W + HALF;
  localparam int TOTAL = NPIX + OFF;
  localparam int PW    = $clog2(TOTAL + 1);

  seq_state_t    state_q, state_d;
  logic [PW-1:0] pos_q, pos_d;
  logic [XW-1:0] cx_q, cx_d;
  logic [YW-1:0] cy_q, cy_d;
  logic          mode_d;
  logic          start;

  always_comb begin
    in_ready = adv && (state_q != ST_DRAIN);
    start    = (state_q == ST_IDLE) && in_valid && in_sof;
    step     = adv && (((state_q == ST_RUN) && in_valid) ||
                       ((state_q == ST_IDLE) && in_valid && in_sof) ||
                       (state_q == ST_DRAIN));
    push_bit = (state_q == ST_DRAIN) ? 1'b0 : in_bit;
    emit     = step && (pos_q >= PW'(OFF));
  end

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    cx_d    = cx_q;
    cy_d    = cy_q;
    mode_d  = mode_q;
    if (step) begin
      unique case (state_q)
        ST_IDLE: begin
          pos_d   = PW'(1);
          state_d = ST_RUN;
          mode_d  = mode_in;
          cx_d    = '0;
          cy_d    = '0;
        end
        ST_RUN: begin
          pos_d = pos_q + 1'b1;
          if (pos_q == PW'(NPIX - 1)) state_d = ST_DRAIN;
        end
        default: begin
          if (pos_q == PW'(TOTAL - 1)) begin
            pos_d   = '0;
            state_d = ST_IDLE;
          end else begin
            pos_d = pos_q + 1'b1;
          end
        end
      endcase
      if (emit) begin
        if (cx_q == XW'(IMG_W - 1)) begin
          cx_d = '0;
          cy_d = cy_q + 1'b1;
        end else begin
          cx_d = cx_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      cx_q    <= '0;
      cy_q    <= '0;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      cx_q    <= cx_d;
      cy_q    <= cy_d;
      mode_q  <= mode_d;
    end
  end

  assign cx = cx_q;
  assign cy = cy_q;

  // R7
  centre_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> (cy_q <= YW'(IMG_H - 1)) && (cx_q <= XW'(IMG_W - 1)));

  // R8
  drain_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN) |-> (pos_q >= PW'(NPIX)));
endmodule

// File: rtl/morph_window.sv
module morph_window
  import morph_pkg::*;
#(
  parameter int IMG_W = 320,
  parameter int IMG_H = 240,
  parameter int XW    = $clog2(IMG_W),
  parameter int YW    = $clog2(IMG_H)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          step,
  input  logic          emit,
  input  logic          push_bit,
  input  logic [XW-1:0] cx,
  input  logic [YW-1:0] cy,
  input  logic          mode_q,
  output logic          res_valid,
  output logic          res_bit,
  output logic [XW-1:0] res_x,
  output logic [YW-1:0] res_y
);
  logic [NLINE-1:0] lb_out;
  logic [KSIZE-1:0] col_in;

  assign col_in = {lb_out, push_bit};

  genvar gk;
  generate
    for (gk = 0; gk < NLINE; gk++) begin : g_line
      morph_linebuf #(.LEN(IMG_W)) u_lb (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (step),
        .din      (col_in[gk]),
        .dout     (lb_out[gk])
      );
    end
  endgenerate

  // window: row k holds pixels k lines back, bit j holds j pixels back
  logic [KSIZE-1:0] win_q [KSIZE];

  generate
    for (gk = 0; gk < KSIZE; gk++) begin : g_win
      always_ff @(posedge clk) begin
        if (step) win_q[gk] <= {win_q[gk][KSIZE-2:0], col_in[gk]};
      end
    end
  endgenerate

  // stage 0 control: centre coordinate of the window contents
  logic          w_valid_q;
  logic [XW-1:0] wx_q;
  logic [YW-1:0] wy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_valid_q <= 1'b0;
      wx_q      <= '0;
      wy_q      <= '0;
    end else if (adv) begin
      w_valid_q <= emit;
      if (emit) begin
        wx_q <= cx;
        wy_q <= cy;
      end
    end
  end

  // stage 1: masked per-row reduction
  logic [KSIZE-1:0] row_ok;
  logic [KSIZE-1:0] col_ok;
  logic [KSIZE-1:0] eff [KSIZE];
  logic [KSIZE-1:0] row_red;
  int               ry;
  int               rx;

  always_comb begin
    for (int k = 0; k < KSIZE; k++) begin
      ry        = int'(wy_q) + HALF - k;
      row_ok[k] = (ry >= 0) && (ry < IMG_H);
      rx        = int'(wx_q) + HALF - k;
      col_ok[k] = (rx >= 0) && (rx < IMG_W);
    end
    for (int k = 0; k < KSIZE; k++) begin
      eff[k] = mode_q ? (win_q[k] | ~col_ok) : (win_q[k] & col_ok);
      if (!row_ok[k])  row_red[k] = mode_q;
      else if (mode_q) row_red[k] = &eff[k];
      else             row_red[k] = |eff[k];
    end
  end

  logic             s1_valid_q;
  logic [KSIZE-1:0] s1_red_q;
  logic [XW-1:0]    s1_x_q;
  logic [YW-1:0]    s1_y_q;
  logic             s1_mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_red_q   <= '0;
      s1_x_q     <= '0;
      s1_y_q     <= '0;
      s1_mode_q  <= 1'b0;
    end else if (adv) begin
      s1_valid_q <= w_valid_q;
      s1_red_q   <= row_red;
      s1_x_q     <= wx_q;
      s1_y_q     <= wy_q;
      s1_mode_q  <= mode_q;
    end
  end

  // stage 2: column reduction
  logic          o_valid_q;
  logic          o_bit_q;
  logic [XW-1:0] o_x_q;
  logic [YW-1:0] o_y_q;
  logic          col_red;

  always_comb col_red = s1_mode_q ? (&s1_red_q) : (|s1_red_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid_q <= 1'b0;
      o_bit_q   <= 1'b0;
      o_x_q     <= '0;
      o_y_q     <= '0;
    end else if (adv) begin
      o_valid_q <= s1_valid_q;
      o_bit_q   <= col_red;
      o_x_q     <= s1_x_q;
      o_y_q     <= s1_y_q;
    end
  end

  assign res_valid = o_valid_q;
  assign res_bit   = o_bit_q;
  assign res_x     = o_x_q;
  assign res_y     = o_y_q;

  // R3
  erode_centre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && w_valid_q && mode_q && !win_q[HALF][HALF]) |=> !s1_red_q[HALF]);

  // R2
  dilate_centre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && w_valid_q && !mode_q && win_q[HALF][HALF]) |=> s1_red_q[HALF]);
endmodule

// File: rtl/morph_stream.sv
module morph_stream
  import morph_pkg::*;
#(
  parameter int IMG_W = 320,
  parameter int IMG_H = 240
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_erode,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  input  logic in_sof,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit,
  output logic out_sof,
  output logic out_eol,
  output logic out_eof
);
  localparam int XW   = $clog2(IMG_W);
  localparam int YW   = $clog2(IMG_H);
  localparam int NPIX = IMG_W * IMG_H;
  localparam int CW   = $clog2(NPIX);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic          adv;
  logic          step;
  logic          emit;
  logic          push_bit;
  logic [XW-1:0] cx;
  logic [YW-1:0] cy;
  logic          mode_q;
  logic          res_valid;
  logic          res_bit;
  logic [XW-1:0] res_x;
  logic [YW-1:0] res_y;

  assign adv = !res_valid || out_ready;

  morph_seq #(.IMG_W(IMG_W), .IMG_H(IMG_H), .XW(XW), .YW(YW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .adv      (adv),
    .in_valid (in_valid),
    .in_sof   (in_sof),
    .in_bit   (in_bit),
    .mode_in  (mode_erode),
    .in_ready (in_ready),
    .step     (step),
    .push_bit (push_bit),
    .emit     (emit),
    .cx       (cx),
    .cy       (cy),
    .mode_q   (mode_q)
  );

  morph_window #(.IMG_W(IMG_W), .IMG_H(IMG_H), .XW(XW), .YW(YW)) u_win (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .adv       (adv),
    .step      (step),
    .emit      (emit),
    .push_bit  (push_bit),
    .cx        (cx),
    .cy        (cy),
    .mode_q    (mode_q),
    .res_valid (res_valid),
    .res_bit   (res_bit),
    .res_x     (res_x),
    .res_y     (res_y)
  );

  always_comb begin
    out_valid = res_valid;
    out_bit   = res_bit;
    out_sof   = (res_x == '0) && (res_y == '0);
    out_eol   = (res_x == XW'(IMG_W - 1));
    out_eof   = out_eol && (res_y == YW'(IMG_H - 1));
  end

  // checker counter: outputs handed over in the current frame
  logic [CW-1:0] out_cnt_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) out_cnt_q <= '0;
    else if (out_valid && out_ready) begin
      if (out_eof) out_cnt_q <= '0;
      else         out_cnt_q <= out_cnt_q + 1'b1;
    end
  end

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_bit) &&
      $stable(out_sof) && $stable(out_eol) && $stable(out_eof));

  // R7
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && out_ready && out_eof) |-> (out_cnt_q == CW'(NPIX - 1)));

  // R7
  frame_start_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && out_sof) |-> (out_cnt_q == '0));
endmodule

// File: tb/morph_stream_tb.sv
`timescale 1ns/1ps
module morph_stream_tb;
  localparam int TW   = 16;
  localparam int TH   = 12;
  localparam int NPIX = TW * TH;

  logic clk = 1'b0;
  logic rst_n;
  logic mode_erode, in_valid, in_ready, in_bit, in_sof;
  logic out_valid, out_ready, out_bit, out_sof, out_eol, out_eof;

  always #10 clk = ~clk;

  morph_stream #(.IMG_W(TW), .IMG_H(TH)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_erode(mode_erode),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit), .in_sof(in_sof),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
    .out_sof(out_sof), .out_eol(out_eol), .out_eof(out_eof)
  );

  int    checks = 0;
  int    errors = 0;
  int    ready_pct = 70;
  bit    done = 0;
  bit    img [TH][TW];
  bit    exp_q[$];
  string tag_q[$];

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic bit ref_px(int x, int y, bit er);
    bit acc;
    acc = er;
    for (int dy = -4; dy <= 4; dy++)
      for (int dx = -4; dx <= 4; dx++)
        if (y + dy >= 0 && y + dy < TH && x + dx >= 0 && x + dx < TW) begin
          if (er) acc = acc & img[y+dy][x+dx];
          else    acc = acc | img[y+dy][x+dx];
        end
    return acc;
  endfunction

  task automatic fill_random(int pct);
    for (int y = 0; y < TH; y++)
      for (int x = 0; x < TW; x++)
        img[y][x] = (($urandom % 100) < pct);
  endtask

  task automatic fill_const(bit v);
    for (int y = 0; y < TH; y++)
      for (int x = 0; x < TW; x++)
        img[y][x] = v;
  endtask

  task automatic send_px(bit b, bit sof);
    bit acc;
    if (($urandom % 4) == 0) begin
      @(posedge clk); #1;
    end
    in_valid = 1'b1; in_bit = b; in_sof = sof;
    do begin
      @(negedge clk);
      acc = in_valid && in_ready;
      @(posedge clk); #1;
    end while (!acc);
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  task automatic send_frame(bit er, string tag, bit flip);
    for (int y = 0; y < TH; y++)
      for (int x = 0; x < TW; x++)
        exp_q.push_back(ref_px(x, y, er));
    tag_q.push_back(tag);
    mode_erode = er;
    for (int i = 0; i < NPIX; i++) begin
      if (flip && i == 5) mode_erode = !er;
      send_px(img[i / TW][i % TW], i == 0);
    end
    // R8: the drain holds off new input right after the last pixel
    @(negedge clk);
    check(in_ready == 1'b0, "R8 in_ready during drain", in_ready, 0);
    @(posedge clk); #1;
  endtask

  // output monitor
  initial begin : mon
    int    idx;
    bit    stalled;
    bit    s_bit, s_sof, s_eol, s_eof;
    string cur;
    bit    e;
    idx = 0; stalled = 0; cur = "";
    forever begin
      @(negedge clk);
      if (rst_n && stalled) begin
        // R9
        check(out_valid && out_bit == s_bit && out_sof == s_sof &&
              out_eol == s_eol && out_eof == s_eof,
              "R9 hold under stall", {out_valid, out_bit, out_sof, out_eol, out_eof},
              {1'b1, s_bit, s_sof, s_eol, s_eof});
      end
      stalled = 0;
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected output", 1, 0);
        end else begin
          if (idx == 0) cur = tag_q.pop_front();
          e = exp_q.pop_front();
          check(out_bit == e, cur, out_bit, e);
          check(out_sof == (idx == 0) && out_eol == ((idx % TW) == TW - 1) &&
                out_eof == (idx == NPIX - 1), "R7 markers",
                {out_sof, out_eol, out_eof},
                {idx == 0, (idx % TW) == TW - 1, idx == NPIX - 1});
          idx = (idx == NPIX - 1) ? 0 : idx + 1;
        end
      end else if (rst_n && out_valid) begin
        stalled = 1; s_bit = out_bit; s_sof = out_sof; s_eol = out_eol; s_eof = out_eof;
      end
    end
  end

  initial begin : rdy
    out_ready = 1'b0;
    forever begin
      @(posedge clk); #1;
      out_ready = (($urandom % 100) < ready_pct);
    end
  end

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired, pending=%0d expected=0", exp_q.size());
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd4051));
    rst_n = 1'b0; mode_erode = 0; in_valid = 0; in_bit = 0; in_sof = 0;
    repeat (4) @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1 reset state",
          {out_valid, in_ready}, 2'b01);
    @(posedge clk); #1;

    fill_random(6);   send_frame(1'b0, "R2 sparse dilation", 1'b0);
    fill_random(92);  send_frame(1'b1, "R3 dense erosion", 1'b0);
    fill_const(1'b1); send_frame(1'b1, "R4 all-ones erosion", 1'b0);
    fill_const(1'b0); img[0][0] = 1; img[TH-1][TW-1] = 1;
    send_frame(1'b0, "R4 corner dilation", 1'b0);

    // R6: stray pixels without a start marker are dropped
    for (int i = 0; i < 6; i++) send_px(1'b1, 1'b0);
    fill_const(1'b0); send_frame(1'b0, "R6 stray pixels dropped", 1'b0);

    // R5: mode flips mid-frame, both directions
    fill_random(85);  send_frame(1'b1, "R5 mode held erosion", 1'b1);
    fill_random(10);  send_frame(1'b0, "R5 mode held dilation", 1'b1);

    // R9: heavy backpressure
    ready_pct = 25;
    fill_random(40);  send_frame(1'b0, "R9 backpressure dilation", 1'b0);
    fill_random(75);  send_frame(1'b1, "R9 backpressure erosion", 1'b0);
    ready_pct = 70;

    while (exp_q.size() != 0) @(posedge clk);
    repeat (20) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule